// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between an on-chip request port and an external 512K x 8 asynchronous static RAM. A client presents one request at a time: a valid flag, a write flag, a 19-bit word address and, for writes, a byte of data. The controller then steps the memory's active-low chip-select, write-strobe and read-strobe lines through a fixed series of phases. The data bus comes out as three separate signals (drive value, sampled value, drive enable), so pad buffers can be added outside the block.

Each phase lasts a whole number of clock cycles, and parameters set those counts. With the default counts and a 100 MHz clock, the memory's slowest-grade minimums are met: 55 ns read access, 40 ns write strobe and 25 ns data setup, plus at least 20 ns after the read strobe rises before the controller drives the bus again. Writes always keep the read strobe high. Every pin-facing signal comes straight from a flip-flop.

Read data is captured into a register and flagged with a one-cycle done pulse. The ready output is high only while the controller is idle.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, chip select, write strobe and read strobe are high (1), bus drive enable is 0, ready is 1 and done is 0.
- R2: Whenever ready is high, chip select is high and bus drive enable is 0, so an idle memory is deselected with its bus released.
- R3: A read accepted at a clock edge holds chip select and read strobe low, with the write strobe high, for exactly RD_SAMPLE_CYC cycles starting in the next cycle. The data input is captured at the edge that ends this window. In the cycle that follows, the captured byte appears on the read data output and done is high.
- R4: A write accepted at a clock edge brings chip select low and drives the write byte from the next cycle on. It waits WR_SETUP_CYC cycles, then holds the write strobe low for exactly WE_LOW_CYC cycles.
- R5: When a write ends, the write strobe rises one cycle before chip select rises and before the bus is released. Done pulses in the cycle in which chip select returns high.
- R6: While chip select is low, the address output equals the accepted request address and does not change. While the bus is driven, the drive value equals the accepted write byte.
- R7: After the done cycle, ready stays low for a further TURN_CYC - 1 cycles. It rises in the cycle TURN_CYC cycles after done rose, so the bus stays quiet after the read strobe rises.
- R8: Requests presented while ready is low are ignored. A request that is withdrawn before ready returns has no effect on the strobes or on memory contents.
- R9: Done is a one-cycle pulse per request. The read data output holds the last read byte until the next read completes.
- R10: The read strobe is never low while the write strobe is low or while the bus drive enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_rdata | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Value to drive on the data bus |
| mem_dq_in | input | 8 | Value sampled from the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The read sample and the release of the read strobe happen on the same clock edge. Capturing one edge late would still look correct to a memory that kept driving the bus. To expose this, the bench's memory model presents valid data only once the read strobe has been low for the full read window, and it replaces that data with a marker byte the moment the read strobe rises. Any read that samples early or late therefore returns the marker, and the comparison against the byte written earlier fails.

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl #(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int WR_SETUP_CYC  = 1,
  parameter int WE_LOW_CYC    = 5,
  parameter int RD_SAMPLE_CYC = 6,
  parameter int TURN_CYC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int MAX_A = (WE_LOW_CYC > RD_SAMPLE_CYC) ? WE_LOW_CYC : RD_SAMPLE_CYC;
  localparam int MAX_B = (WR_SETUP_CYC > TURN_CYC) ? WR_SETUP_CYC : TURN_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_WAIT, ST_SAMPLE, ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER, ST_TURN
  } state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_dq_out <= '0;
      mem_addr   <= '0;
      rsp_rdata  <= '0;
      rsp_done   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              mem_dq_oe  <= 1'b1;
              cnt        <= CNT_W'(WR_SETUP_CYC - 1);
              state      <= ST_WR_SETUP;
            end else begin
              mem_oe_n <= 1'b0;
              cnt      <= CNT_W'(RD_SAMPLE_CYC - 2);
              state    <= ST_RD_WAIT;
            end
          end
        end
        ST_RD_WAIT: begin
          if (cnt_zero) state <= ST_SAMPLE;
          else          cnt   <= cnt - CNT_W'(1);
        end
        ST_SAMPLE: begin
          rsp_rdata <= mem_dq_in;
          rsp_done  <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          cnt       <= CNT_W'(TURN_CYC - 1);
          state     <= ST_TURN;
        end
        ST_WR_SETUP: begin
          if (cnt_zero) begin
            mem_we_n <= 1'b0;
            cnt      <= CNT_W'(WE_LOW_CYC - 1);
            state    <= ST_WR_PULSE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_WR_PULSE: begin
          if (cnt_zero) begin
            mem_we_n <= 1'b1;
            state    <= ST_WR_RECOVER;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_WR_RECOVER: begin
          mem_ce_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          rsp_done  <= 1'b1;
          cnt       <= CNT_W'(TURN_CYC - 1);
          state     <= ST_TURN;
        end
        ST_TURN: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  wr_keeps_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R10
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R5
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/sram_access_ctrl_bench.sv
module sram_access_ctrl_bench;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int S  = 1;
  localparam int W  = 5;
  localparam int RD = 6;
  localparam int T  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'hEE;
  logic [AW-1:0] mem_addr;

  sram_access_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WR_SETUP_CYC(S), .WE_LOW_CYC(W),
                     .RD_SAMPLE_CYC(RD), .TURN_CYC(T)) u_sram_access_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of the request sequencing
  int k = -1;
  int len = 0;
  bit op_wr = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0, m_exp = '0, last_rd = '0;
  logic [DW-1:0] exp_mem [logic [AW-1:0]];

  always @(posedge clk) begin
    if (!rst_n) k = -1;
    else if (k >= 0) begin
      k = k + 1;
      if (k == len) k = -1;
    end else if (req_valid) begin
      k = 0; op_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
      len = req_write ? (S + W + 1 + T) : (RD + T);
      if (req_write) exp_mem[req_addr] = req_wdata;
      else m_exp = exp_mem.exists(req_addr) ? exp_mem[req_addr] : 8'h00;
    end
  end

  // behavioural memory: data valid only after the full read window
  logic [DW-1:0] mem_m [logic [AW-1:0]];
  logic p_ce = 1, p_we = 1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  int oe_cnt = 0;

  always @(negedge clk) begin
    if (!p_ce && !p_we && (mem_ce_n || mem_we_n)) mem_m[p_addr] = p_dq;
    p_ce = mem_ce_n; p_we = mem_we_n; p_addr = mem_addr; p_dq = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) oe_cnt++; else oe_cnt = 0;
    if (oe_cnt >= RD) mem_dq_in = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 8'h00;
    else mem_dq_in = 8'hEE;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic e_ce, e_we, e_oe, e_oe_bus, e_done, e_rdy;
      e_rdy    = (k < 0);
      e_ce     = !(k >= 0 && (op_wr ? (k <= S + W) : (k <= RD - 1)));
      e_oe     = !(k >= 0 && !op_wr && k <= RD - 1);
      e_we     = !(k >= 0 && op_wr && k >= S && k <= S + W - 1);
      e_oe_bus = (k >= 0 && op_wr && k <= S + W);
      e_done   = (k >= 0 && k == (op_wr ? S + W + 1 : RD));
      chk("R8 ready", req_ready, e_rdy);
      chk("R2 chip select", mem_ce_n, e_ce);
      chk("R3 read strobe", mem_oe_n, e_oe);
      chk("R4 write strobe", mem_we_n, e_we);
      chk("R5 bus drive enable", mem_dq_oe, e_oe_bus);
      chk("R9 done", rsp_done, e_done);
      if (!e_ce) chk("R6 address", mem_addr, m_addr);
      if (e_oe_bus) chk("R6 drive value", mem_dq_out, m_wdata);
      if (e_done && !op_wr) last_rd = m_exp;
      chk("R3 read data", rsp_rdata, last_rd);
      if (!mem_oe_n) chk("R10 strobe exclusion", {mem_we_n, mem_dq_oe}, 2'b10);
    end
  end

  task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset values while held
    chk("R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk("R1 reset bus/ready/done", {mem_dq_oe, req_ready, rsp_done}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
    do_req(1, 19'h00000, 8'hA5);
    do_req(1, 19'h7FFFF, 8'h3C);
    do_req(0, 19'h00000, 8'h00);
    do_req(0, 19'h7FFFF, 8'h00);
    do_req(0, 19'h12345, 8'h00);
    // R8: stray request during a busy read, withdrawn before ready returns
    do_req(0, 19'h7FFFF, 8'h00);
    req_valid = 1; req_write = 1; req_addr = 19'h7FFFF; req_wdata = 8'h99;
    repeat (3) @(negedge clk);
    req_valid = 0;
    wait_idle();
    do_req(0, 19'h7FFFF, 8'h00);
    // back-to-back with valid held continuously (R7 turnaround spacing)
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 19'h00100; req_wdata = 8'h5A;
    @(negedge clk);
    req_write = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    lf = 19'h1ACE5;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[17:0], lf[18] ^ lf[17]};
      do_req(1, {15'h0, lf[3:0]}, lf[10:3]);
      lf = {lf[17:0], lf[18] ^ lf[17]};
      do_req(0, {15'h0, lf[3:0]}, 8'h00);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule